// File: doc/BRIEF.md
# Switch Register Access Sequencer over MDIO

This block lets a host reach the 32-bit registers of an Ethernet switch that only exposes a 16-bit MDIO management port. For each upstream request it issues a short chain of MDIO master transactions. The chain opens with a write of the page, which is the upper part of the register address, to a fixed page register. It then transfers the two 16-bit halves of the word. The half-word PHY and register addresses come from the middle bits of the register address. The switch model is chosen by a static select input. The model sets where the page goes, and it sets the order of the halves for one special register.

A second pair of request kinds reaches a PHY behind the switch through the switch's own indirect command register at address 0x98. The block first does a throw-away read of that register. It then writes a command word and polls the register until the busy flag drops. The low 16 bits of the final status word come back as the result. A programmable poll limit ends a command that never completes.

The upstream side takes one request at a time through a valid/ready pair. It answers with a single-cycle response carrying data and an error code. The downstream side drives the request/response port of an MDIO serializer, which sits outside this block.

Top module: `swreg_mdio_bridge`

## Requirements
- R1: `req_ready_o` is high only while no request is in progress. Each accepted request produces exactly one response, which `rsp_valid_o` signals as a one-cycle pulse.
- R2: The first MDIO transaction of every word access is a write of data `addr >> 9`. For `model_i`=0 it goes to PHY 0x1F register 0x10. For `model_i`=1 it goes to PHY 0x18 register 0x00.
- R3: Both half-word transactions use PHY `((addr >> 6) & 7) | 0x10`. Register base+0 carries data bits 15:0, and register base+1 carries bits 31:16, where base = `(addr >> 1) & 0x1E`.
- R4: A register read (`req_kind_i`=0) reads base+0 and then base+1. It returns `{high, low}` with error code 0.
- R5: A register write (`req_kind_i`=1) writes the high half first and the low half second. The one exception is address 0x98 under `model_i`=0, where the low half goes first. The response data is 0.
- R6: An indirect PHY access (`req_kind_i`=2 read, 3 write) starts with a full register read of 0x98 and then writes 0x98 with a command word. The command word sets bits 31 and 30. It places the PHY address in bits 25:21 and the PHY register in bits 20:16. Bit 27 is set for a read. For a write, the data goes in bits 15:0. Every other bit is 0.
- R7: After the command, the block re-reads 0x98 until bit 31 of the word is 0. It then returns `{16'h0, bits 15:0}` of that last word with error code 0.
- R8: If bit 31 is still set after max(`poll_limit_i`, 1) status reads, the access ends with error code 2 and data 0.
- R9: An MDIO response with its error flag set ends the access at once. The response carries error code 1 and data 0, and no further MDIO request is issued.
- R10: When `model_i` is 2 or 3, the request is answered on the cycle after acceptance with error code 3. No MDIO request is issued.
- R11: An MDIO request keeps its valid, write flag, PHY, register and data stable until `mdio_req_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| model_i | input | 2 | Switch model select: 0, 1 valid, others rejected |
| poll_limit_i | input | POLL_W | Maximum busy-status reads of an indirect access |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request accepted when high |
| req_kind_i | input | 2 | 0 reg read, 1 reg write, 2 PHY read, 3 PHY write |
| req_addr_i | input | ADDR_W | Switch register address |
| req_phy_i | input | 5 | PHY address for indirect access |
| req_preg_i | input | 5 | PHY register for indirect access |
| req_wdata_i | input | 32 | Write data (low 16 bits for PHY write) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Response data |
| rsp_err_o | output | 2 | 0 ok, 1 MDIO error, 2 timeout, 3 bad model |
| mdio_req_valid_o | output | 1 | MDIO transaction request |
| mdio_req_ready_i | input | 1 | MDIO master accepts the request |
| mdio_req_write_o | output | 1 | 1 write, 0 read |
| mdio_req_phy_o | output | 5 | MDIO PHY address |
| mdio_req_reg_o | output | 5 | MDIO register address |
| mdio_req_wdata_o | output | 16 | MDIO write data |
| mdio_rsp_valid_i | input | 1 | MDIO transaction finished |
| mdio_rsp_rdata_i | input | 16 | MDIO read data |
| mdio_rsp_err_i | input | 1 | MDIO transaction failed |

## Verification
The bench checks the half order of a write in both cases: address 0x98 under the first model and under the second. A design that applied the special order to every write, or to neither model, would put the two half-word writes in the wrong sequence. Poll limits of 0 and 2 against a switch that stays busy show whether the design ends on the exact status read: an off-by-one counter either issues one read too many or gives up one read early. MDIO errors are injected on a page write and on the last half of a read, which catches a sequencer that keeps issuing requests after a failure. A rejected model value, as well as a page address near the top of the address range, are driven so that any stray or mis-addressed MDIO traffic shows up against the expected transaction queue.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int MDIO_A_W = 5;

  typedef enum logic [1:0] {K_REG_RD = 2'd0, K_REG_WR = 2'd1, K_PHY_RD = 2'd2, K_PHY_WR = 2'd3} kind_e;
  typedef enum logic [1:0] {E_OK = 2'd0, E_MDIO = 2'd1, E_TIMEOUT = 2'd2, E_MODEL = 2'd3} err_e;
  typedef enum logic [1:0] {J_REG, J_DUMMY, J_CMD, J_POLL} job_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;
endpackage

// File: rtl/swreg_addr_map.sv
module swreg_addr_map
  import swreg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] IND_ADDR = ADDR_W'(12'h098)
) (
  input  logic                model_b_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [MDIO_A_W-1:0] page_phy_o,
  output logic [MDIO_A_W-1:0] page_reg_o,
  output logic [HALF_W-1:0]   page_data_o,
  output logic [MDIO_A_W-1:0] half_phy_o,
  output logic [MDIO_A_W-1:0] half_base_o,
  output logic                low_first_o
);
  localparam int PAGE_SHIFT = 9;

  always_comb begin
    page_phy_o  = model_b_i ? 5'h18 : 5'h1f;
    page_reg_o  = model_b_i ? 5'h00 : 5'h10;
    page_data_o = HALF_W'(addr_i >> PAGE_SHIFT);
    half_phy_o  = {2'b10, addr_i[8:6]};
    half_base_o = {addr_i[5:2], 1'b0};
    // first model wants the low half first on the indirect command register
    low_first_o = !model_b_i && (addr_i == IND_ADDR);
  end
endmodule

// File: rtl/swreg_phy_cmd.sv
module swreg_phy_cmd
  import swreg_pkg::*;
(
  input  logic                rd_i,
  input  logic [MDIO_A_W-1:0] phy_i,
  input  logic [MDIO_A_W-1:0] preg_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   cmd_o
);
  always_comb
    cmd_o = {2'b11, 2'b00, rd_i, 1'b0, phy_i, preg_i, rd_i ? {HALF_W{1'b0}} : wdata_i};
endmodule

// File: rtl/swreg_poll_ctr.sv
module swreg_poll_ctr #(
  parameter int POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [POLL_W-1:0] limit_i,
  output logic              last_o
);
  logic [POLL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the read now finishing is read number cnt_q+1
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/swreg_mdio_bridge.sv
module swreg_mdio_bridge
  import swreg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int POLL_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          model_i,
  input  logic [POLL_W-1:0]   poll_limit_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_kind_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [4:0]          req_phy_i,
  input  logic [4:0]          req_preg_i,
  input  logic [31:0]         req_wdata_i,
  output logic                rsp_valid_o,
  output logic [31:0]         rsp_rdata_o,
  output logic [1:0]          rsp_err_o,
  output logic                mdio_req_valid_o,
  input  logic                mdio_req_ready_i,
  output logic                mdio_req_write_o,
  output logic [4:0]          mdio_req_phy_o,
  output logic [4:0]          mdio_req_reg_o,
  output logic [15:0]         mdio_req_wdata_o,
  input  logic                mdio_rsp_valid_i,
  input  logic [15:0]         mdio_rsp_rdata_i,
  input  logic                mdio_rsp_err_i
);
  localparam logic [ADDR_W-1:0] IND_ADDR = ADDR_W'(12'h098);
  localparam logic [1:0] STEP_PAGE = 2'd0;
  localparam logic [1:0] STEP_LAST = 2'd2;

  st_e                 st_q;
  job_e                job_q;
  logic [1:0]          step_q;
  logic                model_b_q;
  logic                phy_rd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                word_wr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [HALF_W-1:0]   lo_q;
  logic [MDIO_A_W-1:0] phy_q, preg_q;
  logic [HALF_W-1:0]   pdata_q;
  logic [WORD_W-1:0]   rdata_q;
  err_e                err_q;

  logic [MDIO_A_W-1:0] page_phy, page_reg, half_phy, half_base;
  logic [HALF_W-1:0]   page_data;
  logic                low_first;
  logic [WORD_W-1:0]   cmd_word;
  logic                poll_clr, poll_inc, poll_last;

  swreg_addr_map #(.ADDR_W(ADDR_W), .IND_ADDR(IND_ADDR)) u_map (
    .model_b_i  (model_b_q),
    .addr_i     (addr_q),
    .page_phy_o (page_phy),
    .page_reg_o (page_reg),
    .page_data_o(page_data),
    .half_phy_o (half_phy),
    .half_base_o(half_base),
    .low_first_o(low_first)
  );

  swreg_phy_cmd u_cmd (
    .rd_i   (phy_rd_q),
    .phy_i  (phy_q),
    .preg_i (preg_q),
    .wdata_i(pdata_q),
    .cmd_o  (cmd_word)
  );

  swreg_poll_ctr #(.POLL_W(POLL_W)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .limit_i(poll_limit_i),
    .last_o (poll_last)
  );

  // request fields come from registers only, so they hold while waiting for ready
  logic hi_sel;
  always_comb begin
    if (word_wr_q) hi_sel = (step_q == 2'd1) ? !low_first : low_first;
    else           hi_sel = (step_q == STEP_LAST);
    mdio_req_valid_o = (st_q == S_ISSUE);
    if (step_q == STEP_PAGE) begin
      mdio_req_write_o = 1'b1;
      mdio_req_phy_o   = page_phy;
      mdio_req_reg_o   = page_reg;
      mdio_req_wdata_o = page_data;
    end else begin
      mdio_req_write_o = word_wr_q;
      mdio_req_phy_o   = half_phy;
      mdio_req_reg_o   = half_base | {4'd0, hi_sel};
      mdio_req_wdata_o = hi_sel ? wdata_q[31:16] : wdata_q[15:0];
    end
  end

  logic rsp_ok, word_end;
  assign rsp_ok   = (st_q == S_WAIT) && mdio_rsp_valid_i && !mdio_rsp_err_i;
  assign word_end = rsp_ok && (step_q == STEP_LAST);
  assign poll_clr = word_end && (job_q == J_CMD);
  assign poll_inc = word_end && (job_q == J_POLL) && mdio_rsp_rdata_i[15] && !poll_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      job_q     <= J_REG;
      step_q    <= STEP_PAGE;
      model_b_q <= 1'b0;
      phy_rd_q  <= 1'b0;
      addr_q    <= '0;
      word_wr_q <= 1'b0;
      wdata_q   <= '0;
      lo_q      <= '0;
      phy_q     <= '0;
      preg_q    <= '0;
      pdata_q   <= '0;
      rdata_q   <= '0;
      err_q     <= E_OK;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          model_b_q <= model_i[0];
          phy_rd_q  <= (req_kind_i == K_PHY_RD);
          phy_q     <= req_phy_i;
          preg_q    <= req_preg_i;
          pdata_q   <= req_wdata_i[15:0];
          wdata_q   <= req_wdata_i;
          step_q    <= STEP_PAGE;
          rdata_q   <= '0;
          err_q     <= E_OK;
          if (req_kind_i[1]) begin
            job_q     <= J_DUMMY;
            addr_q    <= IND_ADDR;
            word_wr_q <= 1'b0;
          end else begin
            job_q     <= J_REG;
            addr_q    <= req_addr_i;
            word_wr_q <= (req_kind_i == K_REG_WR);
          end
          if (model_i[1]) begin
            err_q <= E_MODEL;
            st_q  <= S_DONE;
          end else begin
            st_q  <= S_ISSUE;
          end
        end
        S_ISSUE: if (mdio_req_ready_i) st_q <= S_WAIT;
        S_WAIT: if (mdio_rsp_valid_i) begin
          if (mdio_rsp_err_i) begin
            err_q <= E_MDIO;
            st_q  <= S_DONE;
          end else if (step_q != STEP_LAST) begin
            if (!word_wr_q && step_q == 2'd1) lo_q <= mdio_rsp_rdata_i;
            step_q <= step_q + 2'd1;
            st_q   <= S_ISSUE;
          end else begin
            step_q <= STEP_PAGE;
            unique case (job_q)
              J_REG: begin
                if (!word_wr_q) rdata_q <= {mdio_rsp_rdata_i, lo_q};
                st_q <= S_DONE;
              end
              J_DUMMY: begin
                job_q     <= J_CMD;
                word_wr_q <= 1'b1;
                wdata_q   <= cmd_word;
                st_q      <= S_ISSUE;
              end
              J_CMD: begin
                job_q     <= J_POLL;
                word_wr_q <= 1'b0;
                st_q      <= S_ISSUE;
              end
              J_POLL: begin
                if (!mdio_rsp_rdata_i[15]) begin
                  rdata_q <= {{HALF_W{1'b0}}, lo_q};
                  st_q    <= S_DONE;
                end else if (poll_last) begin
                  err_q <= E_TIMEOUT;
                  st_q  <= S_DONE;
                end else begin
                  st_q  <= S_ISSUE;
                end
              end
              default: st_q <= S_DONE;
            endcase
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign rsp_valid_o = (st_q == S_DONE);
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
endmodule

// File: rtl/swreg_mdio_bridge_chk.sv
module swreg_mdio_bridge_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] model_i,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_err_o,
  input logic       mdio_req_valid_o,
  input logic       mdio_req_ready_i,
  input logic       mdio_req_write_o,
  input logic [4:0] mdio_req_phy_o,
  input logic [4:0] mdio_req_reg_o,
  input logic [15:0] mdio_req_wdata_o,
  input logic       mdio_rsp_valid_i,
  input logic       mdio_rsp_err_i
);
  a_r1_busy_blocks_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_valid_o || rsp_valid_o) |-> !req_ready_o);

  a_r1_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_valid_o && !mdio_req_ready_i) |=>
      (mdio_req_valid_o && $stable(mdio_req_write_o) && $stable(mdio_req_phy_o)
       && $stable(mdio_req_reg_o) && $stable(mdio_req_wdata_o)));

  a_r10_bad_model: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && model_i[1]) |=>
      (rsp_valid_o && rsp_err_o == 2'd3 && !mdio_req_valid_o));

  a_r2_page_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !model_i[1]) |=>
      (mdio_req_valid_o && mdio_req_write_o
       && mdio_req_phy_o == ($past(model_i[0]) ? 5'h18 : 5'h1f)));

  a_r9_err_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_rsp_valid_i && mdio_rsp_err_i && !req_ready_o && !mdio_req_valid_o && !rsp_valid_o) |=>
      (rsp_valid_o && rsp_err_o == 2'd1 && !mdio_req_valid_o));
endmodule

bind swreg_mdio_bridge swreg_mdio_bridge_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .model_i         (model_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_err_o       (rsp_err_o),
  .mdio_req_valid_o(mdio_req_valid_o),
  .mdio_req_ready_i(mdio_req_ready_i),
  .mdio_req_write_o(mdio_req_write_o),
  .mdio_req_phy_o  (mdio_req_phy_o),
  .mdio_req_reg_o  (mdio_req_reg_o),
  .mdio_req_wdata_o(mdio_req_wdata_o),
  .mdio_rsp_valid_i(mdio_rsp_valid_i),
  .mdio_rsp_err_i  (mdio_rsp_err_i)
);

// File: tb/swreg_mdio_bridge_tb.sv
`timescale 1ns/1ps
module swreg_mdio_bridge_tb;
  localparam int ADDR_W = 19;
  localparam int POLL_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]        model;
  logic [POLL_W-1:0] poll_limit;
  logic              req_valid, req_ready;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [4:0]        req_phy, req_preg;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [1:0]        rsp_err;
  logic              m_valid, m_ready, m_write;
  logic [4:0]        m_phy, m_reg;
  logic [15:0]       m_wdata;
  logic              m_rvalid;
  logic [15:0]       m_rdata;
  logic              m_err;

  swreg_mdio_bridge #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .model_i(model), .poll_limit_i(poll_limit),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_phy_i(req_phy), .req_preg_i(req_preg),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .mdio_req_valid_o(m_valid), .mdio_req_ready_i(m_ready),
    .mdio_req_write_o(m_write), .mdio_req_phy_o(m_phy), .mdio_req_reg_o(m_reg),
    .mdio_req_wdata_o(m_wdata), .mdio_rsp_valid_i(m_rvalid),
    .mdio_rsp_rdata_i(m_rdata), .mdio_rsp_err_i(m_err)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] rd;
    logic        er;
  } mdio_item_t;

  typedef struct packed {
    logic [1:0]  err;
    logic [31:0] data;
  } rsp_item_t;

  mdio_item_t mdio_q[$];
  string      mdio_tag_q[$];
  rsp_item_t  rsp_q[$];
  string      rsp_tag_q[$];

  int n_chk = 0;
  int n_err = 0;
  int lat = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_m(input logic wr, input int phy, input int rg, input int wd,
                        input int rd, input logic er, input string tag);
    mdio_item_t it;
    it.wr = wr; it.phy = 5'(phy); it.rg = 5'(rg); it.wd = 16'(wd); it.rd = 16'(rd); it.er = er;
    mdio_q.push_back(it);
    mdio_tag_q.push_back(tag);
  endtask

  // R2 page target
  function automatic int pg_phy(input int m); return (m == 1) ? 'h18 : 'h1f; endfunction
  function automatic int pg_reg(input int m); return (m == 1) ? 'h00 : 'h10; endfunction
  // R3 half addressing
  function automatic int h_phy(input int a); return ((a >> 6) & 7) | 'h10; endfunction
  function automatic int h_base(input int a); return (a >> 1) & 'h1e; endfunction

  task automatic exp_rd(input int m, input int a, input int lo, input int hi);
    push_m(1'b1, pg_phy(m), pg_reg(m), a >> 9, 0, 1'b0, "R2 page");
    push_m(1'b0, h_phy(a), h_base(a), 0, lo, 1'b0, "R4 read low");
    push_m(1'b0, h_phy(a), h_base(a) | 1, 0, hi, 1'b0, "R4 read high");
  endtask

  task automatic exp_wr(input int m, input int a, input logic [31:0] d);
    push_m(1'b1, pg_phy(m), pg_reg(m), a >> 9, 0, 1'b0, "R2 page");
    if (m == 0 && a == 'h98) begin
      push_m(1'b1, h_phy(a), h_base(a), d[15:0], 0, 1'b0, "R5 low first");
      push_m(1'b1, h_phy(a), h_base(a) | 1, d[31:16], 0, 1'b0, "R5 high second");
    end else begin
      push_m(1'b1, h_phy(a), h_base(a) | 1, d[31:16], 0, 1'b0, "R5 high first");
      push_m(1'b1, h_phy(a), h_base(a), d[15:0], 0, 1'b0, "R5 low second");
    end
  endtask

  function automatic logic [31:0] cmd(input bit rd, input int phy, input int rg, input int d);
    logic [31:0] c;
    c = 32'hc000_0000 | (32'(phy & 31) << 21) | (32'(rg & 31) << 16);
    if (rd) c = c | 32'h0800_0000;
    else    c = c | 32'(d & 'hffff);
    return c;
  endfunction

  task automatic exp_rsp(input int err, input logic [31:0] d, input string tag);
    rsp_item_t r;
    r.err = 2'(err); r.data = d;
    rsp_q.push_back(r);
    rsp_tag_q.push_back(tag);
  endtask

  task automatic issue(input int m, input int kind, input int a, input int phy,
                       input int rg, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model = 2'(m); req_kind = 2'(kind); req_addr = ADDR_W'(a);
    req_phy = 5'(phy); req_preg = 5'(rg); req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (rsp_q.size() != 0) @(negedge clk);
    check(mdio_q.size() == 0, "R9 leftover mdio items", 32'(mdio_q.size()), 0);
    mdio_q.delete(); mdio_tag_q.delete();
  endtask

  // MDIO responder and transaction monitor
  initial begin
    m_ready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && m_valid) begin
        mdio_item_t it;
        string tag;
        logic [31:0] act, exp;
        check(!req_ready, "R1 ready low while busy", 32'(req_ready), 0);
        if (mdio_q.size() == 0) begin
          check(1'b0, "R9/R10 unexpected mdio request", {16'd0, 1'b0, m_write, m_phy, m_reg}, 0);
          it = '0;
        end else begin
          it = mdio_q.pop_front();
          tag = mdio_tag_q.pop_front();
          act = {5'd0, m_write, m_phy, m_reg, (m_write ? m_wdata : 16'h0)};
          exp = {5'd0, it.wr, it.phy, it.rg, (it.wr ? it.wd : 16'h0)};
          check(act == exp, tag, act, exp);
        end
        repeat (lat) @(negedge clk);
        check(m_valid, "R11 request held", 32'(m_valid), 1);
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        repeat (lat) @(negedge clk);
        m_rvalid = 1'b1; m_rdata = it.rd; m_err = it.er;
        @(negedge clk);
        m_rvalid = 1'b0; m_err = 1'b0;
        lat = (lat + 1) % 3;
      end
    end
  end

  // upstream response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (rsp_q.size() == 0) begin
          check(1'b0, "R1 unexpected response", {30'd0, rsp_err}, 0);
        end else begin
          rsp_item_t r;
          string tag;
          r = rsp_q.pop_front();
          tag = rsp_tag_q.pop_front();
          check({rsp_err, rsp_rdata[29:0]} == {r.err, r.data[29:0]} && rsp_rdata[31:30] == r.data[31:30],
                tag, rsp_rdata, r.data);
          check(rsp_err == r.err, {tag, " err"}, {30'd0, rsp_err}, {30'd0, r.err});
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    model = 2'd0; poll_limit = 16'd8; req_valid = 1'b0; req_kind = '0;
    req_addr = '0; req_phy = '0; req_preg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 reset rsp", 32'(rsp_valid), 0);
    check(m_valid == 1'b0, "R11 reset mdio idle", 32'(m_valid), 0);

    // R4 read, first model
    exp_rd(0, 'h10c, 'h7fff, 'h1800);
    exp_rsp(0, 32'h1800_7fff, "R4 read data model 0");
    issue(0, 0, 'h10c, 0, 0, 0);

    // R4 read, second model, nonzero page
    exp_rd(1, 'h66c, 'hbeef, 'hdead);
    exp_rsp(0, 32'hdead_beef, "R4 read data model 1");
    issue(1, 0, 'h66c, 0, 0, 0);

    // R5 normal write order
    exp_wr(0, 'h78, 32'h0000_0100);
    exp_rsp(0, 32'h0, "R5 write rsp");
    issue(0, 1, 'h78, 0, 0, 32'h0000_0100);

    // R5 special register, first model: low first
    exp_wr(0, 'h98, 32'hc123_4567);
    exp_rsp(0, 32'h0, "R5 0x98 model 0 rsp");
    issue(0, 1, 'h98, 0, 0, 32'hc123_4567);

    // R5 special register, second model: high first
    exp_wr(1, 'h98, 32'h89ab_cdef);
    exp_rsp(0, 32'h0, "R5 0x98 model 1 rsp");
    issue(1, 1, 'h98, 0, 0, 32'h89ab_cdef);

    // R2/R3 top of address range
    exp_wr(1, 'h7fe5c, 32'h1357_2468);
    exp_rsp(0, 32'h0, "R3 high page write rsp");
    issue(1, 1, 'h7fe5c, 0, 0, 32'h1357_2468);

    // R6/R7 PHY read, one busy poll
    exp_rd(0, 'h98, 'haaaa, 'h0000);
    exp_wr(0, 'h98, cmd(1, 4, 0, 0));
    exp_rd(0, 'h98, 'h5555, 'h8000);
    exp_rd(0, 'h98, 'h1234, 'h0000);
    exp_rsp(0, 32'h0000_1234, "R7 PHY read result");
    issue(0, 2, 0, 4, 0, 0);

    // R6/R7 PHY write, second model
    exp_rd(1, 'h98, 'h0, 'h0);
    exp_wr(1, 'h98, cmd(0, 2, 9, 'h9000));
    exp_rd(1, 'h98, 'h9000, 'h4000);
    exp_rsp(0, 32'h0000_9000, "R6 PHY write result");
    issue(1, 3, 0, 2, 9, 32'h0000_9000);

    // R8 timeout after two busy reads
    poll_limit = 16'd2;
    exp_rd(0, 'h98, 'h0, 'h0);
    exp_wr(0, 'h98, cmd(1, 7, 3, 0));
    exp_rd(0, 'h98, 'h1111, 'h8000);
    exp_rd(0, 'h98, 'h2222, 'hc000);
    exp_rsp(2, 32'h0, "R8 timeout limit 2");
    issue(0, 2, 0, 7, 3, 0);

    // R8 limit 0 behaves as one read
    poll_limit = 16'd0;
    exp_rd(1, 'h98, 'h0, 'h0);
    exp_wr(1, 'h98, cmd(1, 1, 1, 0));
    exp_rd(1, 'h98, 'h0, 'h8000);
    exp_rsp(2, 32'h0, "R8 timeout limit 0");
    issue(1, 2, 0, 1, 1, 0);
    poll_limit = 16'd8;

    // R9 error on last half of read
    push_m(1'b1, pg_phy(1), pg_reg(1), 'h66c >> 9, 0, 1'b0, "R9 page");
    push_m(1'b0, h_phy('h66c), h_base('h66c), 0, 'h1234, 1'b0, "R9 low");
    push_m(1'b0, h_phy('h66c), h_base('h66c) | 1, 0, 'h5678, 1'b1, "R9 high err");
    exp_rsp(1, 32'h0, "R9 mdio error on read");
    issue(1, 0, 'h66c, 0, 0, 0);

    // R9 error on page write
    push_m(1'b1, pg_phy(0), pg_reg(0), 'h40 >> 9, 0, 1'b1, "R9 page err");
    exp_rsp(1, 32'h0, "R9 mdio error on page");
    issue(0, 1, 'h40, 0, 0, 32'hffff_ffff);

    // R10 unsupported models
    exp_rsp(3, 32'h0, "R10 model 2");
    issue(2, 0, 'h10c, 0, 0, 0);
    exp_rsp(3, 32'h0, "R10 model 3");
    issue(3, 2, 0, 4, 0, 0);

    // R1 ready returns after the last response
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after response", 32'(req_ready), 1);

    // R4 read still fine after an abort
    exp_rd(0, 'h0, 'h0001, 'h8000);
    exp_rsp(0, 32'h8000_0001, "R4 read after error");
    issue(0, 0, 'h0, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule